// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block holds the status byte of a serial non-volatile memory. It also decides, request by request, whether a write may go ahead. A command front-end decodes the serial stream and hands the block single-cycle events:
- write enable and write disable;
- status write, together with its data byte;
- array write, together with its byte address and a flag marking the identification page;
- write-cycle done, from the programming sequencer.

The block returns three things:
- the status byte, which the front-end shifts out on a status read;
- a same-cycle permit for each write request, which the front-end uses to start the programming sequencer;
- a busy flag.

The block keeps the volatile write-enable latch and the write-in-progress flag. It also keeps three retained bits: the status-lock bit and two protection-level bits. Retention is modelled as ordinary flops that load a parameter default at reset.

The external write-protect pin is active low. Status writes are refused while the lock bit is 1 and the pin is low. The protection level selects a refused address region: none, the top quarter, the top half, or the whole array plus the identification page. An accepted write sets busy, and the front-end is expected to issue one event per cycle. While busy, every request is ignored until the done event arrives. The done event then clears busy and the write-enable latch, and a pending status write lands at that point.

Top module: `sreg_guard`

## Requirements
- R1: The status byte is {lock bit at bit 7, zeros at bits 6..4, protection level at bits 3..2, write-enable latch at bit 1, busy at bit 0}. Bits 6..4 read 0 even after a status write of 0xFF.
- R2: Reset clears the write-enable latch and busy, and it loads the lock bit and protection level from the parameter RST_NV, given as {lock, level[1:0]}.
- R3: When idle, a write-enable event sets the latch and a write-disable event clears it. Either change is visible in the next cycle.
- R4: With the latch at 0, status and array write requests get permit 0 and leave the status byte unchanged.
- R5: Level 00 protects no address. Level 01 refuses the top quarter, addresses 0xC00..0xFFF at the default width. Level 10 refuses the top half, 0x800..0xFFF. Level 11 refuses every address and the identification page. A refused array write gets permit 0 and busy stays 0. The identification page is refused only at level 11.
- R6: An accepted write gives permit 1 in its request cycle, and busy reads 1 from the next cycle.
- R7: While busy, the done event clears busy and the latch in the next cycle. Busy holds until done, and a done event while idle has no effect.
- R8: An accepted status write takes data bit 7 as the lock bit and data bits 3..2 as the level, and ignores the other data bits. The old lock bit and level stay visible until the done event of that write.
- R9: With the lock bit at 0, a status write is accepted with the pin low or high.
- R10: With the lock bit at 1 and the pin low, a status write gets permit 0 and leaves the latch set. This holds whichever of the two came first. Driving the pin high makes status writes accepted again.
- R11: While busy, write-enable, write-disable, status write and array write requests are ignored and get permit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n_i | input | 1 | Write-protect pin, low means protect |
| ev_wren_i | input | 1 | Write-enable event |
| ev_wrdi_i | input | 1 | Write-disable event |
| ev_srwr_i | input | 1 | Status write request |
| sr_data_i | input | 8 | Data byte of the status write |
| ev_arwr_i | input | 1 | Array write request |
| arwr_addr_i | input | ADDR_W | Byte address of the array write |
| arwr_idpg_i | input | 1 | Array write targets the identification page |
| cyc_done_i | input | 1 | Programming cycle finished |
| status_o | output | 8 | Status byte |
| permit_o | output | 1 | Current request accepted |
| busy_o | output | 1 | Write in progress |

## Verification
The main instance uses the default 12-bit address and an all-clear retained default. At that width the quarter and half boundaries fall at 0xC00 and 0x800, so the bench probes both edges of each, plus the identification page at every level. A second instance uses RST_NV = 3'b111, which makes the locked, fully protected reset state observable directly. The lock is entered both pin-first and bit-first, so both orderings are covered.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;

    // Retained part of the status byte
    typedef struct packed {
        logic       lock;
        logic [1:0] lvl;
    } nv_t;

    typedef struct packed {
        nv_t  nv;
        nv_t  nv_pend;
        logic pend_sr;
        logic wel;
        logic busy;
    } st_t;

    function automatic logic [7:0] pack_status(nv_t nv, logic wel, logic busy);
        return {nv.lock, 3'b000, nv.lvl, wel, busy};
    endfunction

endpackage

// File: rtl/sreg_prot_map.sv
module sreg_prot_map #(
    parameter int ADDR_W = 12
) (
    input  logic [1:0]        lvl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              idpg_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        hit_o = 1'b0;
        unique case (lvl_i)
            2'b00: hit_o = 1'b0;
            2'b01: hit_o = !idpg_i && (addr_i[TOP -: 2] == 2'b11);
            2'b10: hit_o = !idpg_i && addr_i[TOP];
            2'b11: hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sreg_req_gate.sv
module sreg_req_gate (
    input  logic busy_i,
    input  logic wel_i,
    input  logic lock_i,
    input  logic wp_n_i,
    input  logic hit_i,
    output logic sr_ok_o,
    output logic ar_ok_o
);
    logic base_ok;
    logic sr_frozen;

    always_comb begin
        base_ok   = !busy_i && wel_i;
        sr_frozen = lock_i && !wp_n_i;
        sr_ok_o   = base_ok && !sr_frozen;
        ar_ok_o   = base_ok && !hit_i;
    end

endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
    import sreg_guard_pkg::*;
#(
    parameter int         ADDR_W = 12,
    parameter logic [2:0] RST_NV = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              ev_wren_i,
    input  logic              ev_wrdi_i,
    input  logic              ev_srwr_i,
    input  logic [7:0]        sr_data_i,
    input  logic              ev_arwr_i,
    input  logic [ADDR_W-1:0] arwr_addr_i,
    input  logic              arwr_idpg_i,
    input  logic              cyc_done_i,
    output logic [7:0]        status_o,
    output logic              permit_o,
    output logic              busy_o
);
    st_t  st_d, st_q;
    logic hit, sr_ok, ar_ok;

    sreg_prot_map #(.ADDR_W(ADDR_W)) i_map (
        .lvl_i  (st_q.nv.lvl),
        .addr_i (arwr_addr_i),
        .idpg_i (arwr_idpg_i),
        .hit_o  (hit)
    );

    sreg_req_gate i_gate (
        .busy_i  (st_q.busy),
        .wel_i   (st_q.wel),
        .lock_i  (st_q.nv.lock),
        .wp_n_i  (wp_n_i),
        .hit_i   (hit),
        .sr_ok_o (sr_ok),
        .ar_ok_o (ar_ok)
    );

    always_comb begin
        st_d     = st_q;
        permit_o = 1'b0;
        if (st_q.busy) begin
            if (cyc_done_i) begin
                st_d.busy    = 1'b0;
                st_d.wel     = 1'b0;
                st_d.pend_sr = 1'b0;
                if (st_q.pend_sr) begin
                    st_d.nv = st_q.nv_pend;
                end
            end
        end else if (ev_srwr_i) begin
            if (sr_ok) begin
                permit_o          = 1'b1;
                st_d.busy         = 1'b1;
                st_d.pend_sr      = 1'b1;
                st_d.nv_pend.lock = sr_data_i[7];
                st_d.nv_pend.lvl  = sr_data_i[3:2];
            end
        end else if (ev_arwr_i) begin
            if (ar_ok) begin
                permit_o  = 1'b1;
                st_d.busy = 1'b1;
            end
        end else if (ev_wrdi_i) begin
            st_d.wel = 1'b0;
        end else if (ev_wren_i) begin
            st_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.nv      <= nv_t'(RST_NV);
            st_q.nv_pend <= nv_t'(RST_NV);
            st_q.pend_sr <= 1'b0;
            st_q.wel     <= 1'b0;
            st_q.busy    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = pack_status(st_q.nv, st_q.wel, st_q.busy);
    assign busy_o   = st_q.busy;

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(permit_o));

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cyc_done_i) |=> (!busy_o && !status_o[1]));

    // R8
    nv_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable({status_o[7], status_o[3:2]}));

    // R11
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !permit_o);

    // R4
    permit_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        permit_o |-> status_o[1]);

    // R10
    sr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_srwr_i && status_o[7] && !wp_n_i) |-> !permit_o);

    // R5
    full_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_arwr_i && !ev_srwr_i && status_o[3:2] == 2'b11) |-> !permit_o);

endmodule

// File: tb/test_sreg_guard.sv
module test_sreg_guard;
    localparam int AW = 12;
    localparam int NV = 44;

    // {req[3:0], op[2:0], wp, idpg, val[11:0], exp_permit, exp_status[7:0]}
    // op: 0 idle, 1 enable, 2 disable, 3 status write, 4 array write, 5 done
    localparam logic [29:0] VEC [NV] = '{
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h02}, // R3
        {4'd3,  3'd2, 1'b1, 1'b0, 12'h000, 1'b0, 8'h00}, // R3
        {4'd4,  3'd4, 1'b1, 1'b0, 12'h000, 1'b0, 8'h00}, // R4
        {4'd4,  3'd3, 1'b1, 1'b0, 12'h08C, 1'b0, 8'h00}, // R4
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h02},
        {4'd6,  3'd4, 1'b1, 1'b0, 12'h123, 1'b1, 8'h03}, // R6
        {4'd11, 3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h03}, // R11
        {4'd7,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h00}, // R7
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h02},
        {4'd8,  3'd3, 1'b1, 1'b0, 12'h0FF, 1'b1, 8'h03}, // R8
        {4'd8,  3'd0, 1'b1, 1'b0, 12'h000, 1'b0, 8'h03},
        {4'd1,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h8C}, // R1
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h8E},
        {4'd5,  3'd4, 1'b1, 1'b0, 12'h000, 1'b0, 8'h8E}, // R5
        {4'd5,  3'd4, 1'b1, 1'b1, 12'h000, 1'b0, 8'h8E},
        {4'd10, 3'd3, 1'b0, 1'b0, 12'h084, 1'b0, 8'h8E}, // R10
        {4'd10, 3'd3, 1'b1, 1'b0, 12'h084, 1'b1, 8'h8F},
        {4'd11, 3'd2, 1'b1, 1'b0, 12'h000, 1'b0, 8'h8F},
        {4'd8,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h84},
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h86},
        {4'd5,  3'd4, 1'b1, 1'b0, 12'hBFF, 1'b1, 8'h87},
        {4'd7,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h84},
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h86},
        {4'd5,  3'd4, 1'b1, 1'b0, 12'hC00, 1'b0, 8'h86},
        {4'd10, 3'd3, 1'b1, 1'b0, 12'h008, 1'b1, 8'h87},
        {4'd8,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h08},
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h0A},
        {4'd5,  3'd4, 1'b1, 1'b0, 12'h7FF, 1'b1, 8'h0B},
        {4'd7,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h08},
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h0A},
        {4'd5,  3'd4, 1'b1, 1'b0, 12'h800, 1'b0, 8'h0A},
        {4'd5,  3'd4, 1'b1, 1'b1, 12'h000, 1'b1, 8'h0B},
        {4'd7,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h08},
        {4'd3,  3'd1, 1'b1, 1'b0, 12'h000, 1'b0, 8'h0A},
        {4'd9,  3'd3, 1'b0, 1'b0, 12'h000, 1'b1, 8'h0B}, // R9
        {4'd8,  3'd5, 1'b0, 1'b0, 12'h000, 1'b0, 8'h00},
        {4'd3,  3'd1, 1'b0, 1'b0, 12'h000, 1'b0, 8'h02},
        {4'd9,  3'd3, 1'b0, 1'b0, 12'h080, 1'b1, 8'h03},
        {4'd8,  3'd5, 1'b0, 1'b0, 12'h000, 1'b0, 8'h80},
        {4'd3,  3'd1, 1'b0, 1'b0, 12'h000, 1'b0, 8'h82},
        {4'd10, 3'd3, 1'b0, 1'b0, 12'h000, 1'b0, 8'h82},
        {4'd10, 3'd3, 1'b1, 1'b0, 12'h000, 1'b1, 8'h83},
        {4'd7,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h00},
        {4'd7,  3'd5, 1'b1, 1'b0, 12'h000, 1'b0, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          ev_wren = 1'b0, ev_wrdi = 1'b0, ev_srwr = 1'b0;
    logic          ev_arwr = 1'b0, idpg = 1'b0, done = 1'b0;
    logic [7:0]    sr_data = 8'h00;
    logic [AW-1:0] addr = '0;
    logic [7:0]    status, status_b;
    logic          permit, permit_b, busy, busy_b;
    int            n_chk = 0;
    int            n_err = 0;

    always #10 clk = ~clk;

    sreg_guard #(.ADDR_W(AW), .RST_NV(3'b000)) i_sreg_guard (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n),
        .ev_wren_i(ev_wren), .ev_wrdi_i(ev_wrdi), .ev_srwr_i(ev_srwr),
        .sr_data_i(sr_data), .ev_arwr_i(ev_arwr), .arwr_addr_i(addr),
        .arwr_idpg_i(idpg), .cyc_done_i(done),
        .status_o(status), .permit_o(permit), .busy_o(busy)
    );

    sreg_guard #(.ADDR_W(AW), .RST_NV(3'b111)) i_sreg_guard_nv (
        .clk(clk), .rst_n(rst_n), .wp_n_i(1'b1),
        .ev_wren_i(1'b0), .ev_wrdi_i(1'b0), .ev_srwr_i(1'b0),
        .sr_data_i(8'h00), .ev_arwr_i(1'b0), .arwr_addr_i({AW{1'b0}}),
        .arwr_idpg_i(1'b0), .cyc_done_i(1'b0),
        .status_o(status_b), .permit_o(permit_b), .busy_o(busy_b)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_ev();
        ev_wren = 1'b0; ev_wrdi = 1'b0; ev_srwr = 1'b0;
        ev_arwr = 1'b0; done = 1'b0; idpg = 1'b0;
    endtask

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state of both instances
        check("R2 status default", int'(status), 8'h00);
        check("R2 status preset", int'(status_b), 8'h8C);
        check("R2 busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after release", int'(status_b), 8'h8C);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            string       tg;
            v = VEC[i];
            @(negedge clk);
            wp_n = v[22];
            case (v[25:23])
                3'd1: ev_wren = 1'b1;
                3'd2: ev_wrdi = 1'b1;
                3'd3: begin ev_srwr = 1'b1; sr_data = v[16:9]; end
                3'd4: begin ev_arwr = 1'b1; addr = v[20:9]; idpg = v[21]; end
                3'd5: done = 1'b1;
                default: ;
            endcase
            #2;
            tg = $sformatf("R%0d step %0d permit", v[29:26], i);
            check(tg, int'(permit), int'(v[8]));
            @(posedge clk);
            #2;
            clear_ev();
            tg = $sformatf("R%0d step %0d status", v[29:26], i);
            check(tg, int'(status), int'(v[7:0]));
        end

        // R6: busy port mirrors the in-progress bit while a cycle runs
        @(negedge clk);
        ev_wren = 1'b1;
        @(posedge clk); #2; clear_ev();
        @(negedge clk);
        ev_arwr = 1'b1; addr = 12'hFFF;
        @(posedge clk); #2; clear_ev();
        check("R6 busy port", int'(busy), 1);
        repeat (3) @(negedge clk);
        check("R7 busy holds", int'(busy), 1);
        done = 1'b1;
        @(posedge clk); #2; clear_ev();
        check("R7 busy cleared", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule